// File: doc/BRIEF.md
# Chunked Round-Robin Cluster Steering Unit

This unit sits at the dispatch stage of a core whose out-of-order back-end is split into two clusters, each able to issue eight micro-ops per cycle. Every cycle it takes a group of renamed micro-ops and gives each valid slot a cluster ID. The steering is chunked: a fixed number of valid micro-ops in program order, RUN_LEN, goes to one cluster, and then the target changes to the other cluster. RUN_LEN defaults to 64. Small values such as 3 are also supported, for comparison with fine-grained steering. A chunk may span several dispatch groups, and a group may contain one or more chunk boundaries.

Alongside the steering, the unit keeps a table indexed by physical register. The table holds the cluster that produced each register and whether the register is live. When an accepted micro-op reads a live register that was produced in the other cluster, the unit sets a forward-needed bit for that register. The back-end can then gate off the intercluster transfer of every result whose bit stays clear. Freeing a register clears its bit.

The unit stalls a whole group if any cluster that receives a slot from it is stalled. It never redirects a micro-op, so chunk boundaries do not depend on back-pressure. It also shows the run state at the start of each group so that the state can be checkpointed. A flush reloads that state from a recovery input.

Top module: `cluster_steer`

## Requirements
- R1: After every RUN_LEN valid micro-ops the target cluster inverts. The current position within the run, `run_cnt_o`, always stays below RUN_LEN.
- R2: Invalid slots neither take a cluster nor advance the run. A switch happens exactly at the valid slot that follows the RUN_LEN-th micro-op of a chunk, even inside a group. A chunk carries over from one group to the next.
- R3: `dispatch_o` is high when both of these hold: at least one slot is valid and no flush is requested, and no valid slot's assigned cluster has its stall bit set. `stall_i[c]` is the stall bit of cluster c. A group that is not accepted leaves the run state unchanged. An empty group is never accepted.
- R4: A flush loads `flush_cnt_i` and `flush_cl_i` into the run state on the next edge, with priority over dispatch, and the group presented in the flush cycle is dropped.
- R5: `run_cnt_o` and `run_cl_o` give the run position and the target cluster that apply to the first valid slot of the group currently presented.
- R6: `src_remote_o[s][j]` is high for a valid slot whose valid source reads a live register whose producing cluster differs from the slot's cluster. An earlier slot of the same group that writes the register counts as its producer.
- R7: An accepted remote read sets `fwd_need_o` for the register read, and the bit then holds until the register is freed or written again.
- R8: `free_valid_i` with `free_tag_i` clears the live and forward-needed state of that register. An accepted write of a register clears its forward-needed bit. A later slot in the same group may set the bit again.
- R9: A read of a register that has not been written since reset, or since it was last freed, is never flagged remote.
- R10: After reset the run position is 0, the target cluster is 0, and all forward-needed bits are clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| grp_valid_i | input | SLOTS | Valid bit per slot |
| dst_valid_i | input | SLOTS | Slot writes a physical register |
| dst_tag_i | input | SLOTS x TW | Destination physical register |
| src_valid_i | input | SLOTS x SRCS | Source operand reads a register |
| src_tag_i | input | SLOTS x SRCS x TW | Source physical register |
| stall_i | input | 2 | Per-cluster stall |
| flush_i | input | 1 | Reload run state |
| flush_cnt_i | input | CW | Recovered run position |
| flush_cl_i | input | 1 | Recovered target cluster |
| free_valid_i | input | 1 | Register free strobe |
| free_tag_i | input | TW | Register being freed |
| dispatch_o | output | 1 | Group accepted this cycle |
| slot_cl_o | output | SLOTS | Cluster ID per slot |
| src_remote_o | output | SLOTS x SRCS | Source needs an intercluster value |
| run_cnt_o | output | CW | Run position at group start |
| run_cl_o | output | 1 | Target cluster at group start |
| fwd_need_o | output | PREG | Forward-needed bit per physical register |

## Verification
The bench drives a small configuration with 4 slots, a run length of 3 and 16 registers. It cycles through every one of the 16 valid-slot masks several times. Sparse masks check that invalid slots do not advance the run. Dense masks force one or two chunk switches inside a single group, which separates a per-slot count from a per-group count. Tags derived arithmetically make producers and consumers fall sometimes in the same cluster and sometimes in opposite clusters, both within a group and across groups. Periodic stalls of one cluster, frees and flushes with varying recovery values show whether blocked groups, released registers and reloaded state are handled apart from normal dispatch.

// File: rtl/steer_pkg.sv
package steer_pkg;
  localparam int unsigned NUM_CL = 2;
  typedef logic cl_id_t;

  function automatic int unsigned cnt_w(int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/steer_run_sel.sv
module steer_run_sel
  import steer_pkg::*;
#(
  parameter int unsigned SLOTS   = 8,
  parameter int unsigned RUN_LEN = 64,
  localparam int unsigned CW     = cnt_w(RUN_LEN)
) (
  input  logic [SLOTS-1:0] valid_i,
  input  logic [CW-1:0]    cnt_i,
  input  cl_id_t           cl_i,
  output logic [SLOTS-1:0] slot_cl_o,
  output logic [CW-1:0]    cnt_o,
  output cl_id_t           cl_o
);
  localparam logic [CW-1:0] LAST = CW'(RUN_LEN - 1);

  logic [CW-1:0] c_w;
  cl_id_t        k_w;

  // walk slots in program order; switch after the last micro-op of a chunk
  always_comb begin
    c_w       = cnt_i;
    k_w       = cl_i;
    slot_cl_o = '0;
    for (int s = 0; s < SLOTS; s++) begin
      slot_cl_o[s] = k_w;
      if (valid_i[s]) begin
        if (c_w == LAST) begin
          c_w = '0;
          k_w = ~k_w;
        end else begin
          c_w = c_w + 1'b1;
        end
      end
    end
    cnt_o = c_w;
    cl_o  = k_w;
  end
endmodule

// File: rtl/steer_fwd_track.sv
module steer_fwd_track
  import steer_pkg::*;
#(
  parameter int unsigned SLOTS = 8,
  parameter int unsigned SRCS  = 2,
  parameter int unsigned PREG  = 64,
  localparam int unsigned TW   = $clog2(PREG)
) (
  input  logic                              clk_i,
  input  logic                              rst_ni,
  input  logic                              accept_i,
  input  logic [SLOTS-1:0]                  valid_i,
  input  logic [SLOTS-1:0]                  slot_cl_i,
  input  logic [SLOTS-1:0]                  dst_valid_i,
  input  logic [SLOTS-1:0][TW-1:0]          dst_tag_i,
  input  logic [SLOTS-1:0][SRCS-1:0]        src_valid_i,
  input  logic [SLOTS-1:0][SRCS-1:0][TW-1:0] src_tag_i,
  input  logic                              free_valid_i,
  input  logic [TW-1:0]                     free_tag_i,
  output logic [SLOTS-1:0][SRCS-1:0]        src_remote_o,
  output logic [PREG-1:0]                   fwd_need_o
);
  logic [PREG-1:0] live_q, pcl_q, fwd_q;
  logic [PREG-1:0] live_n, pcl_n, fwd_n;
  logic            h_live;
  cl_id_t          h_cl;
  logic [TW-1:0]   t_w;

  // producer lookup with in-group bypass from older slots
  always_comb begin
    src_remote_o = '0;
    h_live       = 1'b0;
    h_cl         = 1'b0;
    t_w          = '0;
    for (int s = 0; s < SLOTS; s++) begin
      for (int j = 0; j < SRCS; j++) begin
        t_w    = src_tag_i[s][j];
        h_live = live_q[t_w];
        h_cl   = pcl_q[t_w];
        for (int e = 0; e < s; e++) begin
          if (valid_i[e] && dst_valid_i[e] && dst_tag_i[e] == t_w) begin
            h_live = 1'b1;
            h_cl   = slot_cl_i[e];
          end
        end
        src_remote_o[s][j] = valid_i[s] && src_valid_i[s][j] && h_live &&
                             (h_cl != slot_cl_i[s]);
      end
    end
  end

  always_comb begin
    live_n = live_q;
    pcl_n  = pcl_q;
    fwd_n  = fwd_q;
    if (free_valid_i) begin
      live_n[free_tag_i] = 1'b0;
      fwd_n[free_tag_i]  = 1'b0;
    end
    if (accept_i) begin
      for (int s = 0; s < SLOTS; s++) begin
        for (int j = 0; j < SRCS; j++) begin
          if (src_remote_o[s][j]) fwd_n[src_tag_i[s][j]] = 1'b1;
        end
        if (valid_i[s] && dst_valid_i[s]) begin
          live_n[dst_tag_i[s]] = 1'b1;
          pcl_n[dst_tag_i[s]]  = slot_cl_i[s];
          fwd_n[dst_tag_i[s]]  = 1'b0;
        end
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      live_q <= '0;
      pcl_q  <= '0;
      fwd_q  <= '0;
    end else begin
      live_q <= live_n;
      pcl_q  <= pcl_n;
      fwd_q  <= fwd_n;
    end
  end

  assign fwd_need_o = fwd_q;
endmodule

// File: rtl/cluster_steer.sv
module cluster_steer
  import steer_pkg::*;
#(
  parameter int unsigned SLOTS   = 8,
  parameter int unsigned SRCS    = 2,
  parameter int unsigned RUN_LEN = 64,
  parameter int unsigned PREG    = 64,
  localparam int unsigned TW     = $clog2(PREG),
  localparam int unsigned CW     = cnt_w(RUN_LEN)
) (
  input  logic                               clk_i,
  input  logic                               rst_ni,
  input  logic [SLOTS-1:0]                   grp_valid_i,
  input  logic [SLOTS-1:0]                   dst_valid_i,
  input  logic [SLOTS-1:0][TW-1:0]           dst_tag_i,
  input  logic [SLOTS-1:0][SRCS-1:0]         src_valid_i,
  input  logic [SLOTS-1:0][SRCS-1:0][TW-1:0] src_tag_i,
  input  logic [NUM_CL-1:0]                  stall_i,
  input  logic                               flush_i,
  input  logic [CW-1:0]                      flush_cnt_i,
  input  logic                               flush_cl_i,
  input  logic                               free_valid_i,
  input  logic [TW-1:0]                      free_tag_i,
  output logic                               dispatch_o,
  output logic [SLOTS-1:0]                   slot_cl_o,
  output logic [SLOTS-1:0][SRCS-1:0]         src_remote_o,
  output logic [CW-1:0]                      run_cnt_o,
  output logic                               run_cl_o,
  output logic [PREG-1:0]                    fwd_need_o
);
  logic [CW-1:0] cnt_q, cnt_nxt;
  cl_id_t        cl_q, cl_nxt;
  logic          stall_hit;

  steer_run_sel #(.SLOTS(SLOTS), .RUN_LEN(RUN_LEN)) u_sel (
    .valid_i   (grp_valid_i),
    .cnt_i     (cnt_q),
    .cl_i      (cl_q),
    .slot_cl_o (slot_cl_o),
    .cnt_o     (cnt_nxt),
    .cl_o      (cl_nxt)
  );

  // whole group waits if any cluster it touches is stalled
  always_comb begin
    stall_hit = 1'b0;
    for (int s = 0; s < SLOTS; s++) begin
      if (grp_valid_i[s] && stall_i[slot_cl_o[s]]) stall_hit = 1'b1;
    end
  end

  assign dispatch_o = (|grp_valid_i) && !stall_hit && !flush_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      cl_q  <= 1'b0;
    end else if (flush_i) begin
      cnt_q <= flush_cnt_i;
      cl_q  <= flush_cl_i;
    end else if (dispatch_o) begin
      cnt_q <= cnt_nxt;
      cl_q  <= cl_nxt;
    end
  end

  steer_fwd_track #(.SLOTS(SLOTS), .SRCS(SRCS), .PREG(PREG)) u_fwd (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .accept_i     (dispatch_o),
    .valid_i      (grp_valid_i),
    .slot_cl_i    (slot_cl_o),
    .dst_valid_i  (dst_valid_i),
    .dst_tag_i    (dst_tag_i),
    .src_valid_i  (src_valid_i),
    .src_tag_i    (src_tag_i),
    .free_valid_i (free_valid_i),
    .free_tag_i   (free_tag_i),
    .src_remote_o (src_remote_o),
    .fwd_need_o   (fwd_need_o)
  );

  assign run_cnt_o = cnt_q;
  assign run_cl_o  = cl_q;
endmodule

// File: rtl/cluster_steer_chk.sv
module cluster_steer_chk
  import steer_pkg::*;
#(
  parameter int unsigned SLOTS   = 8,
  parameter int unsigned SRCS    = 2,
  parameter int unsigned RUN_LEN = 64,
  parameter int unsigned PREG    = 64,
  localparam int unsigned TW     = $clog2(PREG),
  localparam int unsigned CW     = cnt_w(RUN_LEN)
) (
  input logic                  clk_i,
  input logic                  rst_ni,
  input logic [SLOTS-1:0]      grp_valid_i,
  input logic                  flush_i,
  input logic [CW-1:0]         flush_cnt_i,
  input logic                  flush_cl_i,
  input logic                  free_valid_i,
  input logic [TW-1:0]         free_tag_i,
  input logic                  dispatch_o,
  input logic [CW-1:0]         run_cnt_o,
  input logic                  run_cl_o,
  input logic [PREG-1:0]       fwd_need_o
);
  AST_CNT_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_cnt_o <= CW'(RUN_LEN - 1)); // R1

  AST_IDLE_NO_DISPATCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (grp_valid_i == '0) |-> !dispatch_o); // R3

  AST_STALL_HOLDS_RUN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!dispatch_o && !flush_i) |=> ($stable(run_cnt_o) && $stable(run_cl_o))); // R3

  AST_FLUSH_LOADS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> (run_cnt_o == $past(flush_cnt_i) && run_cl_o == $past(flush_cl_i))); // R4

  AST_FWD_STABLE_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!dispatch_o && !free_valid_i) |=> $stable(fwd_need_o)); // R7

  AST_FREE_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (free_valid_i && !dispatch_o) |=> !fwd_need_o[$past(free_tag_i)]); // R8
endmodule

bind cluster_steer cluster_steer_chk #(
  .SLOTS(SLOTS), .SRCS(SRCS), .RUN_LEN(RUN_LEN), .PREG(PREG)
) chk_i (.*);

// File: tb/cluster_steer_tb_top.sv
module cluster_steer_tb_top;
  localparam int SLOTS = 4;
  localparam int SRCS  = 2;
  localparam int N     = 3;
  localparam int PREG  = 16;
  localparam int TW    = 4;
  localparam int CW    = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic [SLOTS-1:0]                   v, dv;
  logic [SLOTS-1:0][TW-1:0]           dtag;
  logic [SLOTS-1:0][SRCS-1:0]         sv;
  logic [SLOTS-1:0][SRCS-1:0][TW-1:0] stag;
  logic [1:0]                         stall;
  logic                               flush, fcl, fvalid;
  logic [CW-1:0]                      fcnt;
  logic [TW-1:0]                      ftag;
  logic                               disp, rcl;
  logic [SLOTS-1:0]                   scl;
  logic [SLOTS-1:0][SRCS-1:0]         srem;
  logic [CW-1:0]                      rcnt;
  logic [PREG-1:0]                    fneed;

  cluster_steer #(.SLOTS(SLOTS), .SRCS(SRCS), .RUN_LEN(N), .PREG(PREG)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .grp_valid_i(v), .dst_valid_i(dv), .dst_tag_i(dtag),
    .src_valid_i(sv), .src_tag_i(stag), .stall_i(stall), .flush_i(flush),
    .flush_cnt_i(fcnt), .flush_cl_i(fcl), .free_valid_i(fvalid), .free_tag_i(ftag),
    .dispatch_o(disp), .slot_cl_o(scl), .src_remote_o(srem), .run_cnt_o(rcnt),
    .run_cl_o(rcl), .fwd_need_o(fneed)
  );

  int n_chk = 0, n_bad = 0;
  bit done = 0;
  int base_cnt = 0, base_cl = 0, g = 0;
  bit last_flush = 0;
  bit m_live [PREG];
  bit m_cl   [PREG];
  bit m_fwd  [PREG];

  task automatic chk(bit ok, string req, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  task automatic step();
    bit ecl [SLOTS];
    bit er  [SLOTS][SRCS];
    bit edisp, lv, pc;
    int p, q, tg;
    logic [PREG-1:0] mv;
    #1;
    q = base_cnt + g;
    chk(rcnt == CW'(q % N), last_flush ? "R4" : "R5", rcnt, q % N);
    chk(rcl == (base_cl ^ ((q / N) % 2)), last_flush ? "R4" : "R5", rcl, base_cl ^ ((q / N) % 2));
    p = 0;
    edisp = (v != 0) && !flush;
    for (int s = 0; s < SLOTS; s++) begin
      ecl[s] = 1'(base_cl ^ (((base_cnt + g + p) / N) % 2));
      if (v[s]) begin
        chk(scl[s] == ecl[s], "R1,R2", scl[s], ecl[s]);
        if (stall[ecl[s]]) edisp = 0;
        p++;
      end
    end
    chk(disp == edisp, "R3", disp, edisp);
    for (int s = 0; s < SLOTS; s++) begin
      for (int j = 0; j < SRCS; j++) begin
        tg = int'(stag[s][j]);
        lv = m_live[tg];
        pc = m_cl[tg];
        for (int e = 0; e < s; e++)
          if (v[e] && dv[e] && int'(dtag[e]) == tg) begin lv = 1; pc = ecl[e]; end
        er[s][j] = v[s] && sv[s][j] && lv && (pc != ecl[s]);
        chk(srem[s][j] == er[s][j], "R6,R9", srem[s][j], er[s][j]);
      end
    end
    @(posedge clk);
    if (fvalid) begin m_live[ftag] = 0; m_fwd[ftag] = 0; end
    if (edisp) begin
      for (int s = 0; s < SLOTS; s++) begin
        for (int j = 0; j < SRCS; j++) if (er[s][j]) m_fwd[stag[s][j]] = 1;
        if (v[s] && dv[s]) begin
          m_live[dtag[s]] = 1; m_cl[dtag[s]] = ecl[s]; m_fwd[dtag[s]] = 0;
        end
      end
      g += p;
    end
    last_flush = flush;
    if (flush) begin base_cnt = int'(fcnt); base_cl = int'(fcl); g = 0; end
    @(negedge clk);
    for (int r = 0; r < PREG; r++) mv[r] = m_fwd[r];
    chk(fneed == mv, "R7,R8", int'(fneed), int'(mv));
  endtask

  initial begin
    #400000;
    $display("FAIL watchdog actual=0 expected=1");
    n_bad++;
    finish_run();
  end

  initial begin
    v = '0; dv = '0; dtag = '0; sv = '0; stag = '0; stall = '0;
    flush = 0; fcnt = '0; fcl = 0; fvalid = 0; ftag = '0;
    for (int r = 0; r < PREG; r++) begin m_live[r] = 0; m_cl[r] = 0; m_fwd[r] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    #1;
    chk(rcnt == 0, "R10", rcnt, 0);
    chk(rcl == 0, "R10", rcl, 0);
    chk(fneed == '0, "R10", int'(fneed), 0);
    chk(disp == 0, "R3", disp, 0);
    @(negedge clk);
    for (int i = 0; i < 96; i++) begin
      v = 4'(i % 16);
      for (int s = 0; s < SLOTS; s++) begin
        dv[s]   = ((i + s) % 3) != 0;
        dtag[s] = 4'((i * 5 + s * 3) % 16);
        for (int j = 0; j < SRCS; j++) begin
          sv[s][j]   = ((i + s + j) % 2) == 0;
          stag[s][j] = 4'((i * 7 + s + j * 11 + 9) % 16);
        end
      end
      stall  = (i % 5 == 4) ? ((i / 5) % 2 == 0 ? 2'b01 : 2'b10) : 2'b00;
      fvalid = (i % 2) == 1;
      ftag   = 4'((i * 3) % 16);
      flush  = (i % 13) == 12;
      fcnt   = CW'(i % N);
      fcl    = 1'(i / 13);
      step();
    end
    v = '0; stall = '0; flush = 0; fvalid = 0;
    step();
    finish_run();
  end
endmodule